// File: doc/BRIEF.md
# Flash Protection Key Unlock

This block guards the destructive flash operations (program, erase and compaction) behind a four-word key lock. The reference keys are not held in the block. After every reset a small sequencer reads them from four fixed word locations near the top of the first 16 KB flash sector, through a 32-bit flash read port. The reads cover byte offsets 0x3FF0, 0x3FF4, 0x3FF8 and 0x3FFC, in that order. While that fetch runs the block reports busy and accepts no key.

Software then writes its candidate keys, one after another, into a single 32-bit key register. Each write is compared with the reference word that the current key index selects. A correct write advances the index. A wrong one sends the sequence back to the first key. When the last key matches, the block becomes unlocked and passes operation requests to the flash controller. It stays unlocked until reset or an explicit relock. Any request made while locked is dropped and leaves a sticky violation flag.

Top module: `flash_key_lock`

## Requirements
- R1: During and straight after reset: busy=1, unlocked=0, key_idx=0, op_go=0, op_kind_out=00 and violation=0.
- R2: After reset the block raises fl_rd_req and presents the byte addresses 0x3FF0, 0x3FF4, 0x3FF8 and 0x3FFC in that order. Each address is held until a cycle with fl_rd_ack=1, in which fl_rd_data is captured as that key. busy falls in the cycle after the fourth acknowledge, and fl_rd_req is low from then on.
- R3: A key write (key_wr=1) while busy=1 has no effect: key_idx stays 0 and unlocked stays 0.
- R4: A key write whose data equals the reference key selected by key_idx advances key_idx by one, visible in the next cycle. When the matching write is the one at index 3, unlocked becomes 1 and key_idx returns to 0.
- R5: A key write whose data differs from the selected reference key sets key_idx to 0 in the next cycle. The following write is compared with key 0, including when a correct later key is written out of order.
- R6: relock=1 clears unlocked and key_idx in the next cycle. It takes precedence over a key write in the same cycle, and that write is discarded.
- R7: Once unlocked, the status stays 1 until reset or relock. Key writes made while unlocked, whatever their data, change neither unlocked nor key_idx.
- R8: An op_req while unlocked=1 gives op_go=1 in the next cycle, with op_kind_out equal to the requested op_kind (01 program, 10 erase, 11 compaction). op_go is 0, and op_kind_out is 00, in every other cycle. A request in the same cycle as the unlocking key write is judged as locked.
- R9: An op_req while unlocked=0 (busy included) sets violation in the next cycle. violation stays 1 until reset, and relock does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fl_rd_req | output | 1 | Flash read request, held until acknowledged |
| fl_rd_addr | output | 24 | Flash byte address of the key word being read |
| fl_rd_ack | input | 1 | Flash read acknowledge; data valid this cycle |
| fl_rd_data | input | 32 | Flash read data |
| key_wr | input | 1 | Key register write strobe |
| key_wdata | input | 32 | Candidate key value |
| relock | input | 1 | Return to the locked state |
| op_req | input | 1 | Program/erase/compaction request |
| op_kind | input | 2 | Requested operation: 01 program, 10 erase, 11 compaction |
| op_go | output | 1 | Operation granted to the flash controller |
| op_kind_out | output | 2 | Granted operation kind, 00 when no grant |
| busy | output | 1 | Reference key fetch in progress |
| unlocked | output | 1 | All four keys matched |
| key_idx | output | 2 | Index of the key expected next |
| violation | output | 1 | Sticky flag: a request arrived while locked |

## Verification
The hardest states to reach from the ports are those where two events meet in one cycle. One is a relock arriving together with a correct key write. Another is an operation request in the very cycle of the final key match. A third is a key write landing inside the fetch window after a mid-run reset. The stimulus forces each of these collisions on purpose. It also varies the flash acknowledge latency word by word, so that the fetch is stretched irregularly and key writes fall while busy is still high. A behavioural reference model, which knows the key contents from the flash image alone, predicts every output on every clock. This includes the fetch address while the request is pending.

// File: rtl/flk_pkg.sv
package flk_pkg;

   typedef enum logic [1:0] {
      OPK_NONE    = 2'b00,
      OPK_PROGRAM = 2'b01,
      OPK_ERASE   = 2'b10,
      OPK_COMPACT = 2'b11
   } flk_op_e;

   typedef enum logic {
      FS_FETCH = 1'b0,
      FS_READY = 1'b1
   } flk_fetch_e;

endpackage

// File: rtl/flk_key_fetch.sv
module flk_key_fetch
   import flk_pkg::*;
#(
   parameter int unsigned KEY_W    = 32,
   parameter int unsigned NUM_KEYS = 4,
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned KEY_BASE = 32'h0000_3FF0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   output logic                       rd_req,
   output logic [ADDR_W-1:0]          rd_addr,
   input  logic                       rd_ack,
   input  logic [KEY_W-1:0]           rd_data,
   output logic                       busy,
   output logic [NUM_KEYS*KEY_W-1:0]  ref_keys
);

   localparam int unsigned IDX_W     = $clog2(NUM_KEYS);
   localparam int unsigned KEY_BYTES = KEY_W / 8;
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(KEY_BASE);
   localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(KEY_BASE + (NUM_KEYS - 1) * KEY_BYTES);
   localparam logic [IDX_W-1:0]  LAST_I = IDX_W'(NUM_KEYS - 1);

   flk_fetch_e        state_q;
   logic [IDX_W-1:0]  fidx_q;
   logic              take;

   assign take    = (state_q == FS_FETCH) && rd_ack;
   assign rd_req  = (state_q == FS_FETCH);
   assign busy    = (state_q == FS_FETCH);
   assign rd_addr = BASE_A + ADDR_W'(fidx_q) * ADDR_W'(KEY_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_FETCH;
         fidx_q  <= '0;
      end else if (take) begin
         if (fidx_q == LAST_I) begin
            state_q <= FS_READY;
            fidx_q  <= '0;
         end else begin
            fidx_q <= fidx_q + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < NUM_KEYS; g++) begin : g_slot
      logic [KEY_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (take && (fidx_q == IDX_W'(g))) begin
            slot_q <= rd_data;
         end
      end
      assign ref_keys[g*KEY_W +: KEY_W] = slot_q;
   end

   AST_FETCH_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr >= BASE_A) && (rd_addr <= TOP_A));  // R2

   AST_FETCH_ENDS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(rd_ack));  // R2

   AST_FETCH_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> $stable(rd_addr));  // R2

endmodule

// File: rtl/flk_key_match.sv
module flk_key_match #(
   parameter int unsigned KEY_W    = 32,
   parameter int unsigned NUM_KEYS = 4,
   localparam int unsigned IDX_W   = $clog2(NUM_KEYS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       busy,
   input  logic [NUM_KEYS*KEY_W-1:0]  ref_keys,
   input  logic                       key_wr,
   input  logic [KEY_W-1:0]           key_wdata,
   input  logic                       relock,
   output logic                       unlocked,
   output logic [IDX_W-1:0]           key_idx
);

   localparam logic [IDX_W-1:0] LAST_I = IDX_W'(NUM_KEYS - 1);

   logic [NUM_KEYS-1:0] hit;
   logic                accept;
   logic                sel_hit;
   logic                unl_q;
   logic [IDX_W-1:0]    idx_q;

   for (genvar g = 0; g < NUM_KEYS; g++) begin : g_cmp
      assign hit[g] = (key_wdata == ref_keys[g*KEY_W +: KEY_W]);
   end

   assign sel_hit = hit[idx_q];
   assign accept  = key_wr && !busy && !unl_q && !relock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unl_q <= 1'b0;
         idx_q <= '0;
      end else if (relock) begin
         unl_q <= 1'b0;
         idx_q <= '0;
      end else if (accept) begin
         if (!sel_hit) begin
            idx_q <= '0;
         end else if (idx_q == LAST_I) begin
            unl_q <= 1'b1;
            idx_q <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign unlocked = unl_q;
   assign key_idx  = idx_q;

   AST_LOCKED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!unlocked && (key_idx == '0)));  // R3

   AST_UNLOCK_NEEDS_LAST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> ($past(key_wr) && ($past(key_idx) == LAST_I)));  // R4

   AST_RELOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      relock |=> (!unlocked && (key_idx == '0)));  // R6

   AST_UNLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && !relock) |=> (unlocked && (key_idx == '0)));  // R7

endmodule

// File: rtl/flk_op_gate.sv
module flk_op_gate
   import flk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        unlocked,
   input  logic        op_req,
   input  logic [1:0]  op_kind,
   output logic        op_go,
   output logic [1:0]  op_kind_out,
   output logic        violation
);

   logic    go_q;
   flk_op_e kind_q;
   logic    viol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_q   <= 1'b0;
         kind_q <= OPK_NONE;
         viol_q <= 1'b0;
      end else begin
         go_q   <= op_req && unlocked;
         kind_q <= (op_req && unlocked) ? flk_op_e'(op_kind) : OPK_NONE;
         if (op_req && !unlocked) begin
            viol_q <= 1'b1;
         end
      end
   end

   assign op_go       = go_q;
   assign op_kind_out = kind_q;
   assign violation   = viol_q;

   AST_NO_GRANT_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_req && !unlocked) |=> !op_go);  // R8

   AST_GRANT_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (op_req && unlocked) |=> (op_go && (op_kind_out == $past(op_kind))));  // R8

   AST_VIOLATION_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      violation |=> violation);  // R9

endmodule

// File: rtl/flash_key_lock.sv
module flash_key_lock
   import flk_pkg::*;
#(
   parameter int unsigned KEY_W    = 32,
   parameter int unsigned NUM_KEYS = 4,
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned KEY_BASE = 32'h0000_3FF0,
   localparam int unsigned IDX_W   = $clog2(NUM_KEYS)
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic               fl_rd_req,
   output logic [ADDR_W-1:0]  fl_rd_addr,
   input  logic               fl_rd_ack,
   input  logic [KEY_W-1:0]   fl_rd_data,
   input  logic               key_wr,
   input  logic [KEY_W-1:0]   key_wdata,
   input  logic               relock,
   input  logic               op_req,
   input  logic [1:0]         op_kind,
   output logic               op_go,
   output logic [1:0]         op_kind_out,
   output logic               busy,
   output logic               unlocked,
   output logic [IDX_W-1:0]   key_idx,
   output logic               violation
);

   localparam int unsigned KEY_BYTES = KEY_W / 8;
   localparam longint unsigned END_A = longint'(KEY_BASE) + longint'(NUM_KEYS * KEY_BYTES);

   if (NUM_KEYS < 2 || (NUM_KEYS & (NUM_KEYS - 1)) != 0) begin : g_bad_keys
      $error("NUM_KEYS must be a power of two, at least 2");
   end
   if (KEY_W < 8 || (KEY_W % 8) != 0) begin : g_bad_width
      $error("KEY_W must be a whole number of bytes");
   end
   if ((KEY_BASE % KEY_BYTES) != 0) begin : g_bad_align
      $error("KEY_BASE must be aligned to the key size");
   end
   if (ADDR_W < 32 && END_A > (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("key window does not fit in ADDR_W");
   end

   logic                       busy_w;
   logic                       unl_w;
   logic [NUM_KEYS*KEY_W-1:0]  ref_keys_w;

   flk_key_fetch #(
      .KEY_W    (KEY_W),
      .NUM_KEYS (NUM_KEYS),
      .ADDR_W   (ADDR_W),
      .KEY_BASE (KEY_BASE)
   ) i_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (fl_rd_req),
      .rd_addr  (fl_rd_addr),
      .rd_ack   (fl_rd_ack),
      .rd_data  (fl_rd_data),
      .busy     (busy_w),
      .ref_keys (ref_keys_w)
   );

   flk_key_match #(
      .KEY_W    (KEY_W),
      .NUM_KEYS (NUM_KEYS)
   ) i_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy_w),
      .ref_keys  (ref_keys_w),
      .key_wr    (key_wr),
      .key_wdata (key_wdata),
      .relock    (relock),
      .unlocked  (unl_w),
      .key_idx   (key_idx)
   );

   flk_op_gate i_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .unlocked    (unl_w),
      .op_req      (op_req),
      .op_kind     (op_kind),
      .op_go       (op_go),
      .op_kind_out (op_kind_out),
      .violation   (violation)
   );

   assign busy     = busy_w;
   assign unlocked = unl_w;

   AST_BUSY_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !op_go);  // R8

   AST_BUSY_REQ_VIOLATES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_req) |=> violation);  // R9

endmodule

// File: tb/test_flash_key_lock.sv
`timescale 1ns/1ps
module test_flash_key_lock;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fl_rd_req;
   logic [23:0] fl_rd_addr;
   logic        fl_rd_ack = 1'b0;
   logic [31:0] fl_rd_data = '0;
   logic        key_wr = 1'b0;
   logic [31:0] key_wdata = '0;
   logic        relock = 1'b0;
   logic        op_req = 1'b0;
   logic [1:0]  op_kind = 2'b00;
   logic        op_go;
   logic [1:0]  op_kind_out;
   logic        busy;
   logic        unlocked;
   logic [1:0]  key_idx;
   logic        violation;

   always #2.5 clk = ~clk;

   flash_key_lock i_flash_key_lock (
      .clk(clk), .rst_n(rst_n),
      .fl_rd_req(fl_rd_req), .fl_rd_addr(fl_rd_addr),
      .fl_rd_ack(fl_rd_ack), .fl_rd_data(fl_rd_data),
      .key_wr(key_wr), .key_wdata(key_wdata), .relock(relock),
      .op_req(op_req), .op_kind(op_kind),
      .op_go(op_go), .op_kind_out(op_kind_out),
      .busy(busy), .unlocked(unlocked), .key_idx(key_idx),
      .violation(violation)
   );

   int vectors = 0;
   int fails   = 0;
   int cycles  = 0;
   int lat_cnt = 0;
   bit done    = 1'b0;

   // flash image: the four keys at 0x3FF0..0x3FFC, address-derived filler elsewhere
   function automatic logic [31:0] flash_word(input logic [23:0] a);
      case (a)
         24'h003FF0: return 32'hA5C3_1E70;
         24'h003FF4: return 32'h0BAD_F00D;
         24'h003FF8: return 32'h7E57_C0DE;
         24'h003FFC: return 32'hC0FF_EE11;
         default:    return {a[15:0], ~a[15:0]};
      endcase
   endfunction

   function automatic logic [31:0] key_of(input int i);
      return flash_word(24'h003FF0 + 24'(4 * i));
   endfunction

   // reference model state
   bit m_busy, m_unl, m_go, m_viol;
   int m_nf, m_idx;
   logic [1:0] m_kind;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 1; m_nf = 0; m_unl = 0; m_idx = 0;
         m_go = 0; m_kind = 2'b00; m_viol = 0;
      end else begin
         m_go   = op_req && m_unl;
         m_kind = (op_req && m_unl) ? op_kind : 2'b00;
         if (op_req && !m_unl) m_viol = 1;
         if (relock) begin
            m_unl = 0; m_idx = 0;
         end else if (key_wr && !m_busy && !m_unl) begin
            if (key_wdata == key_of(m_idx)) begin
               if (m_idx == 3) begin m_unl = 1; m_idx = 0; end
               else m_idx = m_idx + 1;
            end else begin
               m_idx = 0;
            end
         end
         if (m_busy && fl_rd_ack) begin
            m_nf = m_nf + 1;
            if (m_nf == 4) m_busy = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // per-cycle compare, then flash responder
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(busy == m_busy,           "R2/R3 busy",      busy, m_busy);
         chk(unlocked == m_unl,        "R4/R6/R7 unlocked", unlocked, m_unl);
         chk(key_idx == 2'(m_idx),     "R4/R5 key_idx",   key_idx, m_idx);
         chk(op_go == m_go,            "R8 op_go",        op_go, m_go);
         chk(op_kind_out == m_kind,    "R8 op_kind_out",  op_kind_out, m_kind);
         chk(violation == m_viol,      "R9 violation",    violation, m_viol);
         chk(fl_rd_req == m_busy,      "R2 fl_rd_req",    fl_rd_req, m_busy);
         if (m_busy)
            chk(fl_rd_addr == 24'h003FF0 + 24'(4 * m_nf), "R2 fl_rd_addr",
                fl_rd_addr, 24'h003FF0 + 4 * m_nf);
      end
      if (rst_n && fl_rd_req) begin
         if (lat_cnt == 0) begin
            fl_rd_ack  = 1'b1;
            fl_rd_data = flash_word(fl_rd_addr);
            lat_cnt    = int'(fl_rd_addr[3:2]) % 3;
         end else begin
            fl_rd_ack  = 1'b0;
            fl_rd_data = 32'hDEAD_0000;
            lat_cnt    = lat_cnt - 1;
         end
      end else begin
         fl_rd_ack = 1'b0;
         lat_cnt   = 1;
      end
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr(input logic [31:0] v);
      key_wr = 1'b1; key_wdata = v; tick(); key_wr = 1'b0;
   endtask

   task automatic req(input logic [1:0] k);
      op_req = 1'b1; op_kind = k; tick(); op_req = 1'b0; op_kind = 2'b00;
   endtask

   task automatic unlock_all();
      for (int i = 0; i < 4; i++) wr(key_of(i));
   endtask

   task automatic wait_ready();
      while (busy) tick();
      tick();
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick(2); rst_n = 1'b1;
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            fails++; vectors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            done = 1'b1;
         end
      end
   end

   initial begin
      tick(3);
      // R1: reset values while rst_n is low
      chk(busy && !unlocked && key_idx == 0 && !op_go && op_kind_out == 0 && !violation,
          "R1 reset state", {busy, unlocked, key_idx, op_go, op_kind_out, violation}, 8'b1000_0000);
      rst_n = 1'b1;
      // R3: key writes during the fetch are ignored
      wr(key_of(0));
      wr(key_of(1));
      wait_ready();
      // R3: after the fetch, key_idx is still 0 although key 0 was written early
      chk(key_idx == 0, "R3 early write ignored", key_idx, 0);
      // R9: locked request dropped, violation set
      req(2'b01);
      tick();
      // R5: wrong first key, then partial match broken by an out-of-order key
      wr(32'h1234_5678);
      wr(key_of(0));
      wr(key_of(1));
      wr(key_of(3));
      wr(key_of(1));
      tick();
      // R4: full unlock with an op request in the same cycle as the last key (judged locked)
      wr(key_of(0)); wr(key_of(1)); wr(key_of(2));
      key_wr = 1'b1; key_wdata = key_of(3); op_req = 1'b1; op_kind = 2'b10;
      tick();
      key_wr = 1'b0; op_req = 1'b0; op_kind = 2'b00;
      // R8: grants for all kinds
      req(2'b01); req(2'b10); req(2'b11);
      op_req = 1'b1; op_kind = 2'b11; tick(3); op_req = 1'b0; op_kind = 2'b00;
      tick();
      // R7: writes while unlocked do nothing
      wr(32'h0); wr(key_of(0)); wr(key_of(3));
      tick(2);
      // R6: relock, then request is dropped
      relock = 1'b1; tick(); relock = 1'b0;
      req(2'b01);
      // R6: relock together with a correct key write discards the write
      wr(key_of(0)); wr(key_of(1));
      relock = 1'b1; key_wr = 1'b1; key_wdata = key_of(2); tick();
      relock = 1'b0; key_wr = 1'b0;
      wr(key_of(2));
      unlock_all();
      relock = 1'b1; op_req = 1'b1; op_kind = 2'b01; tick();
      relock = 1'b0; op_req = 1'b0; op_kind = 2'b00;
      tick(2);
      // R9: violation survives relock and clears only on reset; R1 again after reset
      do_reset();
      chk(!violation && busy, "R1 state after second reset", {violation, busy}, 2'b01);
      req(2'b11);
      wr(key_of(0));
      wait_ready();
      unlock_all();
      req(2'b10);
      tick(3);
      done = 1'b1;
      #1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      wait (done);
      #20;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule